// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-register memory transfer command into a stream of single-word accesses, one per selected register. A command carries a register-selection mask, a base address, a direction (count up or count down), a timing choice (step the address before or after each access), a load/store flag and a writeback enable. The sequencer counts the selected registers, works out the lowest address the transfer touches and then issues one beat per register: the register index and the word address.

Registers always leave in ascending index order and the lowest-numbered register always gets the lowest address, whatever the direction. A down-counting command therefore begins at base minus four times the register count. When the last beat completes, a one-cycle completion pulse presents the updated base value, base plus or minus four times the count, for the caller to write back.

Both edges that carry data use valid/ready. A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low for the whole sequence. A beat is consumed only in a cycle where `xfer_valid` and `xfer_ready` are both high. While `xfer_ready` is low the current beat is held unchanged, with no time limit. The completion outputs are plain pins.

Top module: `lsm_addr_seq`

## Requirements
- R1: `cmd_ready` is high exactly when no sequence is in progress. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until the completion pulse.
- R2: Beats name every set bit of the register mask exactly once, in ascending index order, on `xfer_reg` (4-bit index, bit i of the mask is register i).
- R3: Up-counting, step-after (`dir_up`=1, `pre_step`=0): beat k has address base + 4k.
- R4: Up-counting, step-before (`dir_up`=1, `pre_step`=1): beat k has address base + 4 + 4k.
- R5: Down-counting with n selected registers: beat k has address base − 4n + 4k when stepping before, and base − 4n + 4 + 4k when stepping after.
- R6: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_reg` and `xfer_addr` hold their values into the next cycle.
- R7: `done` is high for exactly one cycle, the cycle after the clock edge that consumes the last beat. In that cycle `wb_base` equals base + 4n (up) or base − 4n (down), and `wb_write` equals the command's writeback enable.
- R8: An all-zero mask issues no beat. `done` rises in the cycle after acceptance, with `wb_base` equal to the unchanged base.
- R9: `xfer_load` equals the command's load flag on every beat of that command.
- R10: Down-counting, step-before, on mask bits 1 and 4 with base 0x00080014 gives beats (1, 0x0008000C) then (4, 0x00080010), and `wb_base` 0x0008000C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_mask | input | 16 | Register selection mask, bit i selects register i |
| cmd_base | input | 32 | Base address |
| cmd_dir_up | input | 1 | 1 = addresses above base, 0 = below |
| cmd_pre_step | input | 1 | 1 = step before the access, 0 = after |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_wb | input | 1 | Request base writeback |
| xfer_valid | output | 1 | Beat presented |
| xfer_ready | input | 1 | Memory accepts the beat |
| xfer_reg | output | 4 | Register index of the beat |
| xfer_addr | output | 32 | Word address of the beat |
| xfer_load | output | 1 | Direction of the beat |
| done | output | 1 | One-cycle completion pulse |
| wb_write | output | 1 | Writeback strobe, valid with `done` |
| wb_base | output | 32 | Updated base value |

## Verification
Once a command is accepted on an edge, its first beat shows from that edge on. Each consumed beat is replaced by the next one one edge later. `done`, `wb_write` and `wb_base` appear one edge after the final handshake, or one edge after acceptance for an empty mask. The bench drives and samples 2 ns after each rising edge and tracks each expected beat by index, advancing it only after an edge at which it drove `xfer_ready` high. Each comparison is therefore made in exactly the cycle the requirement names, including stalled cycles where the same beat must repeat.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/lsm_prio_pick.sv
// Lowest-set-bit picker: returns index and one-hot of the lowest set bit.
module lsm_prio_pick #(
  parameter int N    = 16,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  assign onehot = mask & (~mask + {{(N-1){1'b0}}, 1'b1});
  assign any    = |mask;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end

  always_comb begin
    if (any) begin
      a_pick_in_mask_r2: assert (mask[idx] && ((mask & ((N'(1) << idx) - N'(1))) == '0))
        else $error("picked bit is not the lowest set bit");
    end
  end
endmodule

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int N   = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0] mask,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(mask[i]);
  end
endmodule

// File: rtl/lsm_addr_plan.sv
// Computes the first beat address and the final base from the count.
module lsm_addr_plan #(
  parameter int AW   = 32,
  parameter int CW   = 5,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic          dir_up,
  input  logic          pre_step,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] final_base
);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  logic [AW-1:0] span;
  logic [AW-1:0] low;

  assign span = AW'(count) * STEP_W;
  assign low  = base - span;

  always_comb begin
    if (dir_up) begin
      first_addr = pre_step ? base + STEP_W : base;
      final_base = base + span;
    end else begin
      first_addr = pre_step ? low : low + STEP_W;
      final_base = low;
    end
  end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int STEP = 4,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [NREG-1:0] cmd_mask,
  input  logic [AW-1:0]   cmd_base,
  input  logic            cmd_dir_up,
  input  logic            cmd_pre_step,
  input  logic            cmd_load,
  input  logic            cmd_wb,
  output logic            xfer_valid,
  input  logic            xfer_ready,
  output logic [IW-1:0]   xfer_reg,
  output logic [AW-1:0]   xfer_addr,
  output logic            xfer_load,
  output logic            done,
  output logic            wb_write,
  output logic [AW-1:0]   wb_base
);
  import lsm_pkg::*;

  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  seq_state_e      state_q;
  logic [NREG-1:0] pend_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   final_q;
  logic            load_q;
  logic            wb_q;
  logic            done_q;

  logic [CW-1:0]   cnt;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   final_base;
  logic [NREG-1:0] pick_oh;
  logic [IW-1:0]   pick_idx;
  logic            pick_any;
  logic            is_last;
  logic            accept;
  logic            beat_fire;

  lsm_popcnt #(.N(NREG)) u_cnt (
    .mask  (cmd_mask),
    .count (cnt)
  );

  lsm_addr_plan #(.AW(AW), .CW(CW), .STEP(STEP)) u_plan (
    .base       (cmd_base),
    .count      (cnt),
    .dir_up     (cmd_dir_up),
    .pre_step   (cmd_pre_step),
    .first_addr (first_addr),
    .final_base (final_base)
  );

  lsm_prio_pick #(.N(NREG)) u_pick (
    .mask   (pend_q),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  assign cmd_ready = (state_q == SEQ_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign xfer_valid = (state_q == SEQ_RUN);
  assign beat_fire = xfer_valid && xfer_ready;
  assign is_last   = ((pend_q & ~pick_oh) == '0);

  assign xfer_reg  = pick_idx;
  assign xfer_addr = addr_q;
  assign xfer_load = load_q;
  assign done      = done_q;
  assign wb_write  = done_q && wb_q;
  assign wb_base   = final_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      final_q <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pend_q  <= cmd_mask;
        addr_q  <= first_addr;
        final_q <= final_base;
        load_q  <= cmd_load;
        wb_q    <= cmd_wb;
        if (cmd_mask == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q <= SEQ_RUN;
        end
      end else if (beat_fire) begin
        pend_q <= pend_q & ~pick_oh;
        addr_q <= addr_q + STEP_W;
        if (is_last) begin
          state_q <= SEQ_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  p_run_has_work_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> pick_any);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_reg));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> !xfer_valid || (xfer_addr == $past(xfer_addr) + STEP_W));

  p_reg_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> !xfer_valid || (xfer_reg > $past(xfer_reg)));

  p_start_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> $past(cmd_valid && cmd_ready));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(cmd_valid && cmd_ready && cmd_mask == '0) |=> !done);

  p_load_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && $past(xfer_valid) |-> $stable(xfer_load));
endmodule

// File: tb/lsm_addr_seq_test.sv
module lsm_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_mask = '0;
  logic [31:0] cmd_base = '0;
  logic        cmd_dir_up = 1'b0;
  logic        cmd_pre_step = 1'b0;
  logic        cmd_load = 1'b0;
  logic        cmd_wb = 1'b0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [3:0]  xfer_reg;
  logic [31:0] xfer_addr;
  logic        xfer_load;
  logic        done;
  logic        wb_write;
  logic [31:0] wb_base;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  lsm_addr_seq uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mask(cmd_mask),
    .cmd_base(cmd_base), .cmd_dir_up(cmd_dir_up), .cmd_pre_step(cmd_pre_step),
    .cmd_load(cmd_load), .cmd_wb(cmd_wb),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_reg(xfer_reg),
    .xfer_addr(xfer_addr), .xfer_load(xfer_load),
    .done(done), .wb_write(wb_write), .wb_base(wb_base)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    cyc++;
  endtask

  // Runs one command and checks every beat and the completion cycle.
  task automatic run_cmd(input logic [15:0] m, input logic [31:0] b, input bit up,
                         input bit pre, input bit ld, input bit wb, input bit stall);
    int n;
    int k;
    int order [16];
    logic [31:0] first;
    logic [31:0] fin;
    bit rdy;
    n = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin order[n] = i; n++; end
    if (up) begin
      first = pre ? b + 32'd4 : b;
      fin   = b + 32'(4 * n);
    end else begin
      first = pre ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
      fin   = b - 32'(4 * n);
    end
    cmd_mask = m; cmd_base = b; cmd_dir_up = up; cmd_pre_step = pre;
    cmd_load = ld; cmd_wb = wb; cmd_valid = 1'b1;
    chk(cmd_ready === 1'b1, "R1 ready when idle", 32'(cmd_ready), 32'd1);
    step();
    cmd_valid = 1'b0;
    k = 0;
    while (k < n) begin
      rdy = stall ? ((cyc + k) % 3 != 2) : 1'b1;
      xfer_ready = rdy;
      chk(xfer_valid === 1'b1, "R6 beat valid", 32'(xfer_valid), 32'd1);
      chk(cmd_ready === 1'b0, "R1 busy", 32'(cmd_ready), 32'd0);
      chk(xfer_reg === 4'(order[k]), "R2 register order", 32'(xfer_reg), 32'(order[k]));
      if (up && !pre)
        chk(xfer_addr === first + 32'(4 * k), "R3 inc-after addr", xfer_addr, first + 32'(4 * k));
      else if (up)
        chk(xfer_addr === first + 32'(4 * k), "R4 inc-before addr", xfer_addr, first + 32'(4 * k));
      else
        chk(xfer_addr === first + 32'(4 * k), "R5 dec addr", xfer_addr, first + 32'(4 * k));
      chk(xfer_load === ld, "R9 load flag", 32'(xfer_load), 32'(ld));
      chk(done === 1'b0, "R7 no early done", 32'(done), 32'd0);
      step();
      if (rdy) k++;
    end
    xfer_ready = 1'b0;
    if (n == 0)
      chk(done === 1'b1 && xfer_valid === 1'b0 && wb_base === b, "R8 empty list", wb_base, b);
    else
      chk(done === 1'b1, "R7 done after last", 32'(done), 32'd1);
    chk(xfer_valid === 1'b0, "R7 no beat at done", 32'(xfer_valid), 32'd0);
    chk(wb_base === fin, "R7 final base", wb_base, fin);
    chk(wb_write === wb, "R7 writeback strobe", 32'(wb_write), 32'(wb));
    step();
    chk(done === 1'b0, "R7 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] m;
    repeat (3) @(posedge clk);
    #2;
    chk(cmd_ready === 1'b1 && xfer_valid === 1'b0 && done === 1'b0, "R1 reset state",
        {29'd0, cmd_ready, xfer_valid, done}, 32'h4);
    rst_n = 1'b1;
    step();
    // R10: two-register full-descending push
    run_cmd(16'h0012, 32'h0008_0014, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(wb_base === 32'h0008_000C, "R10 push result", wb_base, 32'h0008_000C);
    for (int mode = 0; mode < 4; mode++) begin
      for (int st = 0; st < 2; st++) begin
        for (int j = 0; j < 24; j++) begin
          case (j)
            0: m = 16'h0000;
            1: m = 16'hFFFF;
            2: m = 16'h0001;
            3: m = 16'h8000;
            default: m = 16'((j * 40503) ^ (j << 5) ^ (mode * 4369));
          endcase
          run_cmd(m, 32'h1000_0000 + 32'(j * 256), mode[1], mode[0], j[0], j[1], st[0]);
        end
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule